// File: doc/BRIEF.md
# One-Wire Slave ROM Command Responder

This block is the addressing layer of a one-wire slave device. A slot-level front end, outside this block, turns the wire into two kinds of pulses. One pulse marks a bus reset. The other marks a finished time slot, together with the level sampled in that slot. In return, this block supplies the level the device should present in each read slot. After every bus reset the block takes in one 8-bit ROM command, least significant bit first. It then carries out that command against a 64-bit device identity that is fixed by parameters.

The block supports five commands: read identity, match, skip, search and alarm search. The search arbitration is done bit by bit. For each identity bit the device sends its own bit, then the complement of that bit, and then reads the master's chosen direction. It drops out of the search as soon as the master's choice differs from its own bit. The alarm search works the same way, but the device takes part only while its alarm input is high. When addressing succeeds, the block raises `selected`, which enables the function-command layer. `selected` stays high until the next bus reset.

Top module: `owire_rom_layer`

## Requirements
- R1: After `rst_n` is low, the block waits for a ROM command, with `selected` low and `tx_bit` high.
- R2: Command bits are taken one per slot strobe, least significant bit first. The codes are 33h read identity, 55h match, CCh skip, F0h search and ECh alarm search.
- R3: After read identity, the next 64 slots present the identity least significant bit first on `tx_bit`. `selected` rises after the 64th slot.
- R4: The identity has the family code in bits 7:0 and the serial number in bits 55:8. Bits 63:56 hold a CRC over bits 55:0. The CRC uses the polynomial x^8+x^5+x^4+1, starts from zero and takes the data LSB first.
- R5: After match, 64 received bits that equal the identity raise `selected`. On the first bit that differs, the block goes idle, and slots are then ignored until a bus reset.
- R6: Skip raises `selected` on the 8th command bit, with no identity exchange. `selected` then stays high until a bus reset.
- R7: During search, each identity bit takes three slots. In the first the device presents the bit, in the second its complement, and in the third it reads the master's choice. A choice that differs from the device's bit makes `tx_bit` stay high from then on.
- R8: A search that completes all 64 bits does not raise `selected`. No later slot is acted on until a bus reset.
- R9: Alarm search behaves like search when `alarm_flag` is high on the 8th command bit. Otherwise the device stays released and idle until a bus reset.
- R10: Any other command code makes the block idle until a bus reset. While idle, `selected` is low and `tx_bit` is high.
- R11: `tx_bit` is 1 whenever the block is not presenting a 0. This includes while it is selected.
- R12: A `bus_reset` pulse at any point returns the block to waiting for a command. If it arrives in the same cycle as a slot strobe, the reset wins and the strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle pulse: a reset was seen on the wire |
| slot_strobe | input | 1 | One-cycle pulse: a time slot has finished |
| slot_bit | input | 1 | Level sampled on the wire in the finished slot |
| alarm_flag | input | 1 | Alarm condition from the function layer |
| tx_bit | output | 1 | Level to present in the next read slot (1 = release) |
| selected | output | 1 | Device is addressed and the function layer is enabled |

## Verification
A wrong bit counter or a wrong search phase shows up within one slot on `tx_bit`. A bit is then presented out of place, a complement is missing, or the device goes on driving after it should have dropped out. A wrong decode of the command or the state shows up as `selected` rising or staying low on the slot after the 8th command bit or the 64th identity bit. An ignored or mishandled reset shows up as a misaligned command on the very next byte. The bench therefore samples `tx_bit` before every read slot and `selected` after every command and identity boundary.

// File: rtl/owire_rom_layer.sv
`timescale 1ns/1ps
module owire_rom_layer #(
  parameter logic [7:0]  FAMILY = 8'h22,
  parameter logic [47:0] SERIAL = 48'h0000_5A3C_91E7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic slot_strobe,
  input  logic slot_bit,
  input  logic alarm_flag,
  output logic tx_bit,
  output logic selected
);

  function automatic logic [7:0] crc_of(input logic [55:0] d);
    logic [7:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  localparam logic [63:0] IDENT = {crc_of({SERIAL, FAMILY}), SERIAL, FAMILY};
  localparam logic [7:0] OP_READ  = 8'h33;
  localparam logic [7:0] OP_MATCH = 8'h55;
  localparam logic [7:0] OP_SKIP  = 8'hCC;
  localparam logic [7:0] OP_SRCH  = 8'hF0;
  localparam logic [7:0] OP_ASRCH = 8'hEC;

  typedef enum logic [2:0] {S_CMD, S_READ, S_MATCH, S_SRCH, S_SEL, S_IDLE} st_t;

  st_t        st;
  logic [5:0] cnt;
  logic [1:0] ph;
  logic [6:0] sh;
  logic [7:0] code_next;
  logic       id_bit;
  logic       srch_send;

  assign code_next = {slot_bit, sh};
  assign id_bit    = IDENT[cnt];
  assign srch_send = (st == S_SRCH) && (ph == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_CMD;
      cnt <= '0;
      ph  <= '0;
      sh  <= '0;
    end else if (bus_reset) begin
      st  <= S_CMD;
      cnt <= '0;
      ph  <= '0;
    end else if (slot_strobe) begin
      case (st)
        S_CMD: begin
          sh  <= code_next[7:1];
          cnt <= cnt + 6'd1;
          if (cnt == 6'd7) begin
            cnt <= '0;
            case (code_next)
              OP_READ:  st <= S_READ;
              OP_MATCH: st <= S_MATCH;
              OP_SKIP:  st <= S_SEL;
              OP_SRCH:  st <= S_SRCH;
              OP_ASRCH: st <= alarm_flag ? S_SRCH : S_IDLE;
              default:  st <= S_IDLE;
            endcase
          end
        end
        S_READ: begin
          cnt <= cnt + 6'd1;
          if (cnt == 6'd63) st <= S_SEL;
        end
        S_MATCH: begin
          cnt <= cnt + 6'd1;
          if (slot_bit != id_bit)  st <= S_IDLE;
          else if (cnt == 6'd63)   st <= S_SEL;
        end
        S_SRCH: begin
          if (ph == 2'd2) begin
            ph  <= '0;
            cnt <= cnt + 6'd1;
            if (slot_bit != id_bit || cnt == 6'd63) st <= S_IDLE;
          end else begin
            ph <= ph + 2'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    tx_bit = 1'b1;
    if (st == S_READ) tx_bit = id_bit;
    else if (st == S_SRCH && ph == 2'd0) tx_bit = id_bit;
    else if (st == S_SRCH && ph == 2'd1) tx_bit = ~id_bit;
  end

  assign selected = (st == S_SEL);

endmodule

// File: rtl/owire_rom_layer_chk.sv
`timescale 1ns/1ps
module owire_rom_layer_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_reset,
  input logic slot_strobe,
  input logic tx_bit,
  input logic selected,
  input logic srch_send
);

  p_reset_releases_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!selected && tx_bit));

  p_sel_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && !bus_reset) |=> selected);

  p_sel_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    selected |-> tx_bit);

  p_sel_after_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected) |-> $past(slot_strobe));

  p_complement_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_send && slot_strobe && !bus_reset) |=> (tx_bit == !$past(tx_bit)));

endmodule

bind owire_rom_layer owire_rom_layer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .slot_strobe(slot_strobe),
  .tx_bit(tx_bit), .selected(selected), .srch_send(srch_send)
);

// File: tb/test_owire_rom_layer.sv
`timescale 1ns/1ps
module test_owire_rom_layer;
  localparam logic [7:0]  FAM = 8'h22;
  localparam logic [47:0] SER = 48'h0000_5A3C_91E7;

  logic clk = 1'b0, rst_n = 1'b0, bus_reset = 1'b0, slot_strobe = 1'b0;
  logic slot_bit = 1'b0, alarm_flag = 1'b0;
  logic tx_bit, selected;
  int total = 0, bad = 0;
  logic [63:0] exp_id;

  always #5 clk = ~clk;

  owire_rom_layer #(.FAMILY(FAM), .SERIAL(SER)) i_owire_rom_layer (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .slot_strobe(slot_strobe),
    .slot_bit(slot_bit), .alarm_flag(alarm_flag), .tx_bit(tx_bit), .selected(selected));

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] r = 8'h00;
    for (int k = 0; k < 56; k++) begin
      if ((r[0] ^ d[k]) == 1'b1) r = {1'b1, r[7:1]} ^ 8'h0C;
      else                       r = {1'b0, r[7:1]};
    end
    return r;
  endfunction

  // {cmd[7:0], alarm, expected selected, expected first tx bit}
  localparam logic [10:0] VEC [0:6] = '{
    {8'hCC, 1'b0, 1'b1, 1'b1},
    {8'h33, 1'b0, 1'b0, 1'b0},
    {8'h55, 1'b0, 1'b0, 1'b1},
    {8'hF0, 1'b0, 1'b0, 1'b0},
    {8'hEC, 1'b1, 1'b0, 1'b0},
    {8'hEC, 1'b0, 1'b0, 1'b1},
    {8'hA5, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic b);
    @(negedge clk); slot_bit = b; slot_strobe = 1'b1;
    @(negedge clk); slot_strobe = 1'b0;
  endtask

  task automatic rd(output logic b);
    b = tx_bit;
    wr(b);
  endtask

  task automatic bus_rst();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] c);
    for (int i = 0; i < 8; i++) wr(c[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a, b;
    logic [63:0] got;
    logic errs;
    exp_id = {ref_crc({SER, FAM}), SER, FAM};
    repeat (3) @(negedge clk);
    chk("R1 selected", {63'd0, selected}, 64'd0);
    chk("R1 tx_bit", {63'd0, tx_bit}, 64'd1);
    rst_n = 1'b1;

    // R2 command decode table
    for (int v = 0; v < 7; v++) begin
      alarm_flag = VEC[v][2];
      bus_rst();
      send_byte(VEC[v][10:3]);
      chk("R2 selected after cmd", {63'd0, selected}, {63'd0, VEC[v][1]});
      chk("R2 first tx bit", {63'd0, tx_bit}, {63'd0, VEC[v][0]});
    end
    alarm_flag = 1'b0;

    // R3 / R4 read identity
    bus_rst(); send_byte(8'h33);
    for (int i = 0; i < 64; i++) begin
      rd(a); got[i] = a;
      if (i < 63) chk("R3 not yet selected", {63'd0, selected}, 64'd0);
    end
    chk("R3 identity", got, exp_id);
    chk("R4 family", {56'd0, got[7:0]}, {56'd0, 8'h22});
    chk("R4 crc", {56'd0, got[63:56]}, {56'd0, ref_crc({SER, FAM})});
    chk("R3 selected", {63'd0, selected}, 64'd1);
    chk("R11 released when selected", {63'd0, tx_bit}, 64'd1);

    // R5 match good
    bus_rst(); send_byte(8'h55);
    for (int i = 0; i < 64; i++) wr(exp_id[i]);
    chk("R5 match selected", {63'd0, selected}, 64'd1);

    // R5 match mismatch at bit 40
    bus_rst(); send_byte(8'h55);
    for (int i = 0; i < 64; i++) wr(i == 40 ? ~exp_id[i] : exp_id[i]);
    chk("R5 mismatch not selected", {63'd0, selected}, 64'd0);
    send_byte(8'hCC);
    chk("R10 idle ignores skip", {63'd0, selected}, 64'd0);
    chk("R10 idle released", {63'd0, tx_bit}, 64'd1);

    // R7 / R8 full search
    bus_rst(); send_byte(8'hF0);
    errs = 1'b0;
    for (int i = 0; i < 64; i++) begin
      rd(a); rd(b);
      if (a !== exp_id[i] || b !== ~exp_id[i]) errs = 1'b1;
      wr(exp_id[i]);
    end
    chk("R7 search bit/complement pairs", {63'd0, errs}, 64'd0);
    chk("R8 search not selected", {63'd0, selected}, 64'd0);
    send_byte(8'hCC);
    chk("R8 nothing accepted after search", {63'd0, selected}, 64'd0);
    chk("R8 released after search", {63'd0, tx_bit}, 64'd1);

    // R7 dropout at bit 5
    bus_rst(); send_byte(8'hF0);
    for (int i = 0; i < 6; i++) begin
      rd(a); rd(b);
      wr(i == 5 ? ~exp_id[i] : exp_id[i]);
    end
    rd(a); rd(b);
    chk("R7 dropped out bit", {63'd0, a}, 64'd1);
    chk("R7 dropped out complement", {63'd0, b}, 64'd1);

    // R9 alarm search taking part
    alarm_flag = 1'b1;
    bus_rst(); send_byte(8'hEC);
    alarm_flag = 1'b0;
    rd(a); rd(b);
    chk("R9 alarm search bit", {62'd0, a, b}, {62'd0, exp_id[0], ~exp_id[0]});

    // R12 reset mid-read, then reset coincident with a strobe
    bus_rst(); send_byte(8'h33);
    for (int i = 0; i < 10; i++) rd(a);
    bus_rst(); send_byte(8'hCC);
    chk("R12 reset mid read", {63'd0, selected}, 64'd1);
    @(negedge clk); bus_reset = 1'b1; slot_strobe = 1'b1; slot_bit = 1'b1;
    @(negedge clk); bus_reset = 1'b0; slot_strobe = 1'b0;
    chk("R12 reset clears selected", {63'd0, selected}, 64'd0);
    send_byte(8'hCC);
    chk("R12 strobe with reset ignored", {63'd0, selected}, 64'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule